// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of a four-bank single-data-rate SDRAM from the moment reset is released. It first keeps the memory quiet for a long stabilisation interval. It then closes every bank, runs a train of auto-refresh cycles and loads the mode register with the configured CAS latency, burst length and burst type. Every wait interval is a parameter counted in clock cycles. When the last interval has elapsed, a ready flag rises and stays high.

After initialisation the block keeps the array alive. An interval timer, whose period gives 8192 refreshes every 64 ms, marks a refresh as owed. The block serves each owed refresh as a precharge-all followed by an auto-refresh, so all banks are closed when the refresh is issued. A user agent that wants the command bus raises a request and gets a grant. While the grant is held the block drives NOP. A refresh that comes due during a grant is counted and served after the grant is released. No new grant is given while any refresh is still owed.

Top module: `sdram_bootref`

## Requirements
- R1: From a clock edge that samples reset high, ready and user_gnt are low, CKE is high and the pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111). NOP is held through PWR_CYC cycles, counting the reset-edge cycle as the first.
- R2: On the cycle after the power-up wait, the block issues precharge-all: pins 0010 with address bit 10 high and every other address bit low.
- R3: TRP_CYC cycles after the precharge-all the first auto-refresh (pins 0001) appears. INIT_REF auto-refreshes follow in total, TRC_CYC cycles apart.
- R4: TRC_CYC cycles after the last initial refresh, one mode-register load appears (pins 0000, bank address 0). Address bits [2:0] hold the burst code (1→0, 2→1, 4→2, 8→3). Bit 3 is 1 for an interleaved burst and 0 for a sequential one. Bits [6:4] hold the CAS latency. All other address bits are 0.
- R5: ready rises exactly TMRD_CYC cycles after the mode-register load and stays high until the next reset.
- R6: Each non-NOP command is followed by NOP until its interval has elapsed: TRP_CYC after a precharge, TRC_CYC after a refresh, TMRD_CYC after a mode load.
- R7: With ready high, a refresh comes due every REFI_CYC cycles, counted from the first ready cycle. The block serves each one as precharge-all, then TRP_CYC cycles later an auto-refresh. The precharge-all appears one cycle after the block sees the refresh owed while idle.
- R8: If the block is idle with ready high, nothing owed and user_req high, user_gnt rises on the next cycle. It stays high while user_req is high and falls on the cycle after user_req falls. The pins carry NOP while user_gnt is high.
- R9: Refreshes that come due while user_gnt is high are counted, not dropped. After the release, each one is served back to back as in R7, and a grant request is refused until none is owed.
- R10: Reset asserted at any point, including during a grant, drops ready and user_gnt and restarts the full power-up order of R1 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| user_req | input | 1 | User agent asks for the command bus |
| ready | output | 1 | Initialisation complete |
| user_gnt | output | 1 | Command bus handed to the user agent |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address, always 0 |
| sd_addr | output | ADDR_W | Address: precharge-all flag or mode word |

## Verification
The bench builds the block with a 20-cycle power-up wait, TRP_CYC of 3, TRC_CYC of 5, TMRD_CYC of 2, eight initial refreshes and a 60-cycle refresh interval. With these values the whole start-up takes 65 cycles, so several refresh periods and a second start-up fit in a short run. It sets CAS latency 3, burst length 4 and an interleaved burst, which differ from the defaults and put a non-trivial mode word on the pins. A grant held for about 140 cycles crosses two refresh deadlines and so exercises the owed count. A one-cycle drop in the request between grants exercises refusal while refreshes are owed.

// File: rtl/sdrseq_pkg.sv
package sdrseq_pkg;

    // Pin order {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_IPRE,
        ST_IREF,
        ST_MRS,
        ST_WAIT,
        ST_IDLE,
        ST_GNT,
        ST_RPRE,
        ST_RREF
    } seq_st_e;

    // Address bit that selects all banks on a precharge
    localparam int unsigned PREALL_BIT = 10;
    localparam int unsigned MODE_W     = 16;

    function automatic logic [2:0] burst_code(input int unsigned bl);
        case (bl)
            1:       return 3'd0;
            2:       return 3'd1;
            4:       return 3'd2;
            8:       return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

    function automatic logic [MODE_W-1:0] mode_word(input int unsigned cas,
                                                    input int unsigned bl,
                                                    input bit          ilv);
        logic [MODE_W-1:0] w;
        w      = '0;
        w[2:0] = burst_code(bl);
        w[3]   = ilv;
        w[6:4] = 3'(cas);
        return w;
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sdrseq_refresh_timer.sv
module sdrseq_refresh_timer #(
    parameter int unsigned REFI_CYC = 390,
    parameter int unsigned OWED_W   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ref_done,
    output logic owed_nz
);
    localparam int unsigned TC_W = $clog2(REFI_CYC + 1);
    localparam logic [TC_W-1:0]   TC_LOAD  = TC_W'(REFI_CYC - 1);
    localparam logic [OWED_W-1:0] OWED_MAX = '1;

    logic [TC_W-1:0]   tc;
    logic [OWED_W-1:0] owed;
    logic              tick, inc, dec;

    assign tick = run && (tc == '0);
    assign inc  = tick && (owed != OWED_MAX);
    assign dec  = ref_done && (owed != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tc   <= TC_LOAD;
            owed <= '0;
        end else begin
            if (!run || tick) tc <= TC_LOAD;
            else              tc <= tc - 1'b1;
            case ({inc, dec})
                2'b10:   owed <= owed + 1'b1;
                2'b01:   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    assign owed_nz = (owed != '0);

    p_ref_only_when_owed_r9: assert property (@(posedge clk) disable iff (rst)
        ref_done |-> (owed != '0));

    p_owed_quiet_before_run_r7: assert property (@(posedge clk) disable iff (rst)
        !run |-> (owed == '0));

endmodule

// File: rtl/sdrseq_fsm.sv
module sdrseq_fsm
    import sdrseq_pkg::*;
#(
    parameter int unsigned PWR_CYC  = 10000,
    parameter int unsigned TRP_CYC  = 3,
    parameter int unsigned TRC_CYC  = 4,
    parameter int unsigned TMRD_CYC = 2,
    parameter int unsigned INIT_REF = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     user_req,
    input  logic     owed_nz,
    output sdr_cmd_e op,
    output logic     ready,
    output logic     gnt,
    output logic     ref_issue
);
    localparam int unsigned WMAX = max4(PWR_CYC, TRP_CYC, TRC_CYC, TMRD_CYC);
    localparam int unsigned WC_W = $clog2(WMAX + 1);
    localparam int unsigned IR_W = $clog2(INIT_REF + 1);
    localparam logic [WC_W-1:0] WC_PWR = WC_W'(PWR_CYC - 1);
    localparam logic [WC_W-1:0] WC_RP  = WC_W'(TRP_CYC - 2);
    localparam logic [WC_W-1:0] WC_RC  = WC_W'(TRC_CYC - 2);
    localparam logic [WC_W-1:0] WC_MRD = WC_W'(TMRD_CYC - 2);
    localparam logic [IR_W-1:0] IR_LAST = IR_W'(INIT_REF - 1);

    seq_st_e         st, st_n, ret_st, ret_n;
    logic [WC_W-1:0] wc, wc_n;
    logic [IR_W-1:0] irc, irc_n;

    always_comb begin
        st_n  = st;
        ret_n = ret_st;
        wc_n  = wc;
        irc_n = irc;
        op    = CMD_NOP;
        case (st)
            ST_PWRUP: begin
                if (wc == '0) st_n = ST_IPRE;
                else          wc_n = wc - 1'b1;
            end
            ST_IPRE: begin
                op    = CMD_PRE;
                wc_n  = WC_RP;
                ret_n = ST_IREF;
                st_n  = ST_WAIT;
            end
            ST_IREF: begin
                op    = CMD_REF;
                irc_n = irc + 1'b1;
                wc_n  = WC_RC;
                ret_n = (irc == IR_LAST) ? ST_MRS : ST_IREF;
                st_n  = ST_WAIT;
            end
            ST_MRS: begin
                op    = CMD_MRS;
                wc_n  = WC_MRD;
                ret_n = ST_IDLE;
                st_n  = ST_WAIT;
            end
            ST_WAIT: begin
                if (wc == '0) st_n = ret_st;
                else          wc_n = wc - 1'b1;
            end
            ST_IDLE: begin
                if (owed_nz)       st_n = ST_RPRE;
                else if (user_req) st_n = ST_GNT;
            end
            ST_GNT: begin
                if (!user_req) st_n = ST_IDLE;
            end
            ST_RPRE: begin
                op    = CMD_PRE;
                wc_n  = WC_RP;
                ret_n = ST_RREF;
                st_n  = ST_WAIT;
            end
            ST_RREF: begin
                op    = CMD_REF;
                wc_n  = WC_RC;
                ret_n = ST_IDLE;
                st_n  = ST_WAIT;
            end
            default: st_n = ST_PWRUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_PWRUP;
            ret_st <= ST_IDLE;
            wc     <= WC_PWR;
            irc    <= '0;
            ready  <= 1'b0;
        end else begin
            st     <= st_n;
            ret_st <= ret_n;
            wc     <= wc_n;
            irc    <= irc_n;
            ready  <= ready | (st_n == ST_IDLE);
        end
    end

    assign gnt       = (st == ST_GNT);
    assign ref_issue = (st == ST_RREF);

    p_gnt_follows_req_r8: assert property (@(posedge clk) disable iff (rst)
        gnt |-> $past(user_req));

    p_ready_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    p_no_gnt_before_ready_r1: assert property (@(posedge clk) disable iff (rst)
        gnt |-> ready);

endmodule

// File: rtl/sdrseq_cmd_encode.sv
module sdrseq_cmd_encode
    import sdrseq_pkg::*;
#(
    parameter int unsigned       ADDR_W = 13,
    parameter int unsigned       BA_W   = 2,
    parameter logic [MODE_W-1:0] MODE   = '0
) (
    input  sdr_cmd_e          op,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);
    assign {cs_n, ras_n, cas_n, we_n} = op;
    assign ba = '0;

    for (genvar b = 0; b < ADDR_W; b++) begin : g_abit
        if (b < MODE_W) begin : g_mode
            assign addr[b] = (op == CMD_MRS) ? MODE[b]
                                             : ((op == CMD_PRE) && (b == PREALL_BIT));
        end else begin : g_high
            assign addr[b] = 1'b0;
        end
    end

endmodule

// File: rtl/sdram_bootref.sv
module sdram_bootref
    import sdrseq_pkg::*;
#(
    parameter int unsigned PWR_CYC          = 10000,
    parameter int unsigned TRP_CYC          = 3,
    parameter int unsigned TRC_CYC          = 4,
    parameter int unsigned TMRD_CYC         = 2,
    parameter int unsigned INIT_REF         = 8,
    parameter int unsigned REFI_CYC         = 390,
    parameter int unsigned OWED_W           = 3,
    parameter int unsigned CAS_LATENCY      = 2,
    parameter int unsigned BURST_LEN        = 8,
    parameter bit          BURST_INTERLEAVE = 1'b0,
    parameter int unsigned ADDR_W           = 13,
    parameter int unsigned BA_W             = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              user_req,
    output logic              ready,
    output logic              user_gnt,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr
);
    localparam logic [MODE_W-1:0] MODE_VAL =
        mode_word(CAS_LATENCY, BURST_LEN, BURST_INTERLEAVE);

    sdr_cmd_e op;
    logic     owed_nz, ref_issue;

    assign sd_cke = 1'b1;

    sdrseq_fsm #(
        .PWR_CYC (PWR_CYC),
        .TRP_CYC (TRP_CYC),
        .TRC_CYC (TRC_CYC),
        .TMRD_CYC(TMRD_CYC),
        .INIT_REF(INIT_REF)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .user_req (user_req),
        .owed_nz  (owed_nz),
        .op       (op),
        .ready    (ready),
        .gnt      (user_gnt),
        .ref_issue(ref_issue)
    );

    sdrseq_refresh_timer #(
        .REFI_CYC(REFI_CYC),
        .OWED_W  (OWED_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (ready),
        .ref_done(ref_issue),
        .owed_nz (owed_nz)
    );

    sdrseq_cmd_encode #(
        .ADDR_W(ADDR_W),
        .BA_W  (BA_W),
        .MODE  (MODE_VAL)
    ) u_enc (
        .op   (op),
        .cs_n (sd_cs_n),
        .ras_n(sd_ras_n),
        .cas_n(sd_cas_n),
        .we_n (sd_we_n),
        .addr (sd_addr),
        .ba   (sd_ba)
    );

    p_gnt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        user_gnt |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111));

    p_cmd_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        (!sd_cs_n && ({sd_ras_n, sd_cas_n, sd_we_n} != 3'b111))
        |=> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111));

endmodule

// File: tb/sdram_bootref_tb_top.sv
`timescale 1ns/1ps
module sdram_bootref_tb_top;
    localparam int TP   = 20;
    localparam int TRP  = 3;
    localparam int TRC  = 5;
    localparam int TMRD = 2;
    localparam int NREF = 8;
    localparam int REFI = 60;
    localparam int R    = TP + TRP + NREF * TRC + TMRD;
    localparam int MRS_AT = TP + TRP + NREF * TRC;

    localparam logic [3:0] K_NOP = 4'b0111;
    localparam logic [3:0] K_PRE = 4'b0010;
    localparam logic [3:0] K_REF = 4'b0001;
    localparam logic [3:0] K_MRS = 4'b0000;
    // burst 4 -> code 2, interleaved -> bit 3, CAS 3 -> bits 6:4
    localparam logic [12:0] EXP_MODE = 13'h3A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        user_req = 1'b0;
    logic        ready, user_gnt, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;

    always #10 clk = ~clk;

    sdram_bootref #(
        .PWR_CYC(TP), .TRP_CYC(TRP), .TRC_CYC(TRC), .TMRD_CYC(TMRD),
        .INIT_REF(NREF), .REFI_CYC(REFI), .OWED_W(3),
        .CAS_LATENCY(3), .BURST_LEN(4), .BURST_INTERLEAVE(1'b1),
        .ADDR_W(13), .BA_W(2)
    ) dut_i (
        .clk(clk), .rst(rst), .user_req(user_req), .ready(ready), .user_gnt(user_gnt),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
    );

    int n_chk = 0;
    int n_fail = 0;
    int c = 0;
    int owed = 0;
    int ref_at = -1;
    int idle_at = -1;
    int mst = 0;            // 0 init, 1 idle, 2 granted, 3 busy with refresh
    bit started = 1'b0;
    bit mid_rst = 1'b0;
    bit defer = 1'b0;
    bit finished = 1'b0;
    logic [3:0]  e_cmd = K_NOP;
    logic [12:0] e_addr = '0;
    bit e_gnt = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, c, act, expv);
        end
    endtask

    function automatic logic [3:0] init_cmd(input int k);
        if (k == TP) return K_PRE;
        if (k == MRS_AT) return K_MRS;
        for (int i = 0; i < NREF; i++)
            if (k == TP + TRP + i * TRC) return K_REF;
        return K_NOP;
    endfunction

    // reference model
    always @(posedge clk) begin
        logic [3:0] p_cmd;
        int p_mst, p_owed;
        bit req;
        started = 1'b1;
        if (rst) begin
            c = 0; owed = 0; ref_at = -1; idle_at = -1; mst = 0; defer = 1'b0;
            e_cmd = K_NOP; e_gnt = 1'b0;
        end else begin
            p_cmd = e_cmd; p_mst = mst; p_owed = owed; req = user_req;
            c++;
            if (c > R && (c - R) % REFI == 0) begin
                owed++;
                if (p_mst == 2) defer = 1'b1;
            end
            if (p_cmd == K_REF && (c - 1) > R) owed--;
            e_cmd = K_NOP;
            if (c < R) begin
                e_cmd = init_cmd(c);
            end else if (c == R) begin
                mst = 1;
            end else begin
                case (p_mst)
                    1: begin
                        if (p_owed > 0) begin
                            e_cmd = K_PRE; mst = 3; ref_at = c + TRP;
                        end else if (req) mst = 2;
                    end
                    2: mst = req ? 2 : 1;
                    3: begin
                        if (c == ref_at) begin
                            e_cmd = K_REF; idle_at = c + TRC;
                        end else if (c == idle_at) mst = 1;
                    end
                    default: mst = 1;
                endcase
            end
            if (mst == 1 && owed == 0) defer = 1'b0;
            e_gnt = (mst == 2);
        end
        e_addr = (e_cmd == K_PRE) ? 13'h400 : (e_cmd == K_MRS) ? EXP_MODE : 13'h0;
    end

    // compare away from the active edge
    always @(negedge clk) begin
        string tag, rtag, gtag;
        if (started && !finished) begin
            if (mid_rst && c < TP)        tag = "R10";
            else if (c < TP)              tag = "R1";
            else if (c < R) begin
                if (e_cmd == K_PRE)      tag = "R2";
                else if (e_cmd == K_REF) tag = "R3";
                else if (e_cmd == K_MRS) tag = "R4";
                else                     tag = "R6";
            end else if (mst == 3 && e_cmd == K_NOP) tag = "R6";
            else if (defer)              tag = "R9";
            else                         tag = "R7";
            rtag = (mid_rst && c < TP) ? "R10" : (c < TP) ? "R1" : "R5";
            gtag = (mid_rst && c < TP) ? "R10" : (owed > 0 || defer) ? "R9" : "R8";
            chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == e_cmd, tag, "command pins",
                {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, e_cmd);
            chk(sd_addr == e_addr && sd_ba == 2'b00 && sd_cke == 1'b1, tag,
                "addr/ba/cke", {sd_cke, sd_ba, sd_addr}, {1'b1, 2'b00, e_addr});
            chk(ready == (c >= R), rtag, "ready", ready, (c >= R));
            chk(user_gnt == e_gnt, gtag, "user_gnt", user_gnt, e_gnt);
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL R5 watchdog: actual %0d cycles expected below %0d", wd, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (R + 5) @(negedge clk);
        // R8: short grant with nothing owed
        user_req = 1'b1; repeat (10) @(negedge clk);
        user_req = 1'b0; repeat (5) @(negedge clk);
        // R9: long grant across two refresh deadlines
        user_req = 1'b1; repeat (140) @(negedge clk);
        user_req = 1'b0; @(negedge clk);
        user_req = 1'b1; repeat (40) @(negedge clk);
        user_req = 1'b0;
        // R7: idle through a periodic refresh
        repeat (80) @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            user_req = i[0];
            repeat (3) @(negedge clk);
        end
        // R10: reset during a grant
        user_req = 1'b1; repeat (6) @(negedge clk);
        rst = 1'b1; mid_rst = 1'b1; @(negedge clk);
        rst = 1'b0; user_req = 1'b0;
        repeat (R + 70) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule